// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Flag

A single-clock first-in first-out buffer. Its default size is 9 bits by 4096 words, and both are parameters. A producer pushes words through a valid/ready pair. A consumer pulls words through a ready/available pair and gets a registered data word with a one-cycle valid strobe. Three status outputs report the fill state: empty, full, and above-half. The above-half flag is set once occupancy goes past half the depth, and it clears once occupancy is back at half or below.

A rewind input moves the read position back to the first location and leaves the write position where it is. Everything written since reset can then be read again. After a rewind, the occupancy becomes the number of locations between location zero and the write position. This is meaningful only while fewer than depth words have been written since reset. Reads and writes are independent and may happen in the same cycle.

Back-pressure works as follows:
- On the write side, `wr_ready` is low exactly while the buffer is full, and a word is taken on any cycle where `wr_valid && wr_ready`.
- On the read side, `rd_avail` is high whenever the buffer holds data. A word is removed on any cycle where `rd_ready && rd_avail` and rewind is low.
- Neither ready signal depends combinationally on the other side's inputs.

Top module: `rewind_fifo`

## Requirements
- R1: While and after synchronous active-high reset, both positions return to location zero, `empty`=1, `full`=0, `half_full`=0, `rd_data_valid`=0 and `rd_data`=0.
- R2: While `full`=1, `wr_ready`=0 and an offered write is dropped: neither the contents nor the occupancy change.
- R3: While `empty`=1, a read request is dropped: the next cycle `rd_data_valid`=0 and `rd_data` keeps its value.
- R4: With no reads since reset, `full` rises in the cycle after the DEPTH-th accepted write, and not before.
- R5: `half_full` is 1 exactly when occupancy exceeds DEPTH/2. It rises after the write that crosses that point and falls after the read that brings occupancy back to DEPTH/2.
- R6: Words leave in the order they were accepted. The cycle after an accepted read, `rd_data` holds the word and `rd_data_valid`=1.
- R7: A rewind cycle sets the read position to location zero and leaves the write position unchanged. The occupancy becomes the write position plus any write accepted in that cycle, and the flags follow the new value.
- R8: An accepted read and an accepted write in the same cycle leave occupancy unchanged. When the buffer is empty, only the write takes place.
- R9: On cycles with no accepted read, `rd_data` holds its previous value and `rd_data_valid`=0.
- R10: A read requested in the same cycle as a rewind is not performed (`rd_data_valid`=0 the next cycle), while a write in that cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Buffer can take a word (not full) |
| wr_data | input | WIDTH | Word to store |
| rd_ready | input | 1 | Consumer requests a word |
| rd_avail | output | 1 | Buffer holds at least one word |
| rd_data | output | WIDTH | Registered output word |
| rd_data_valid | output | 1 | `rd_data` was updated by a read this cycle |
| rewind | input | 1 | Move read position back to location zero |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| half_full | output | 1 | Occupancy exceeds DEPTH/2 |

## Verification
The hardest state to reach from the ports is a rewind after a partial drain, particularly one that coincides with a read and a write in the same cycle. At that point the occupancy jumps to a value that ordinary pushes and pops never produce in one step. The bench reaches it from a fresh reset: it counts out a known number of writes, drains part of them, and then pulses rewind, both alone and together with a read and a write. A near-exhaustive sweep then runs a small depth-16 instance through fill-past-full, drain-past-empty, the half-depth boundary in both directions, and a long pattern of mixed traffic with periodic resets and rewinds. Every output is compared against an arithmetic occupancy-and-order model on every cycle.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  localparam int unsigned RWF_DEF_WIDTH = 9;
  localparam int unsigned RWF_DEF_DEPTH = 4096;

  // Operations accepted in one cycle, after gating by the flags.
  typedef struct packed {
    logic push;
    logic pop;
    logic rewind;
  } rwf_op_t;
endpackage

// File: rtl/rwf_ptr.sv
// Wrapping location counter with a synchronous return to zero.
module rwf_ptr #(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clr,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == '0)); // R7
endmodule

// File: rtl/rwf_occ.sv
// Occupancy counter and status flags.
module rwf_occ
  import rwf_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned OCC_W = $clog2(DEPTH + 1),
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  rwf_op_t          op,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] occ_d;

  always_comb begin
    if (op.rewind) begin
      // read position returns to zero: distance is the write position
      occ_d = OCC_W'(wr_ptr) + OCC_W'(op.push);
    end else begin
      occ_d = occ_q;
      if (op.push) occ_d = occ_d + OCC_W'(1);
      if (op.pop)  occ_d = occ_d - OCC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_d;
  end

  assign empty     = (occ_q == '0);
  assign full      = (occ_q == OCC_W'(DEPTH));
  assign half_full = (occ_q > OCC_W'(HALF));

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !op.pop && !op.rewind) |=> full); // R2
  AST_FULL_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(op.push)); // R4
  AST_HALF_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(half_full) |-> $past(op.push || op.rewind)); // R5
endmodule

// File: rtl/rwf_store.sv
// Word storage with a registered read port.
module rwf_store #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop;
      if (pop) rd_data <= mem[rd_ptr];
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data)); // R9
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import rwf_pkg::*;
#(
  parameter int unsigned WIDTH = RWF_DEF_WIDTH,
  parameter int unsigned DEPTH = RWF_DEF_DEPTH,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_avail,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_data_valid,
  input  logic             rewind,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  rwf_op_t          op;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  // writes blocked only by full; reads by empty or a concurrent rewind
  assign op.push   = wr_valid && !full;
  assign op.pop    = rd_ready && !empty && !rewind;
  assign op.rewind = rewind;

  assign wr_ready = !full;
  assign rd_avail = !empty;

  rwf_ptr #(.DEPTH(DEPTH)) i_wr_ptr (
    .clk (clk),
    .rst (rst),
    .step(op.push),
    .clr (1'b0),
    .ptr (wr_ptr)
  );

  rwf_ptr #(.DEPTH(DEPTH)) i_rd_ptr (
    .clk (clk),
    .rst (rst),
    .step(op.pop),
    .clr (op.rewind),
    .ptr (rd_ptr)
  );

  rwf_occ #(.DEPTH(DEPTH)) i_occ (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .wr_ptr   (wr_ptr),
    .empty    (empty),
    .full     (full),
    .half_full(half_full)
  );

  rwf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
    .clk     (clk),
    .rst     (rst),
    .push    (op.push),
    .pop     (op.pop),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .rd_valid(rd_data_valid)
  );

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (rst)
    empty |=> !rd_data_valid); // R3
  AST_REWIND_NO_READ: assert property (@(posedge clk) disable iff (rst)
    rewind |=> !rd_data_valid); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(empty && (full || half_full))); // R1
endmodule

// File: tb/test_rewind_fifo.sv
module test_rewind_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;
  localparam int W = 9;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [W-1:0] wr_data = '0;
  logic         rd_ready = 1'b0;
  logic         rd_avail;
  logic [W-1:0] rd_data;
  logic         rd_data_valid;
  logic         rewind = 1'b0;
  logic         empty;
  logic         full;
  logic         half_full;

  rewind_fifo #(.WIDTH(W), .DEPTH(D)) i_rewind_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_ready(rd_ready), .rd_avail(rd_avail),
    .rd_data(rd_data), .rd_data_valid(rd_data_valid), .rewind(rewind),
    .empty(empty), .full(full), .half_full(half_full)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic [W-1:0] m_mem [D];
  int           m_wp, m_rp, m_cnt, m_wtot;
  int           m_data;
  bit           m_valid;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "empty", int'(empty), int'(m_cnt == 0));
    check(tag, "full", int'(full), int'(m_cnt == D));
    check(tag, "half_full", int'(half_full), int'(m_cnt > D / 2));
    check(tag, "wr_ready", int'(wr_ready), int'(m_cnt < D));
    check(tag, "rd_avail", int'(rd_avail), int'(m_cnt > 0));
    check(tag, "rd_data_valid", int'(rd_data_valid), int'(m_valid));
    check(tag, "rd_data", int'(rd_data), m_data);
  endtask

  task automatic step(string tag, bit wv, int wd, bit rr, bit rw);
    bit push, pop;
    @(negedge clk);
    wr_valid = wv; wr_data = W'(wd); rd_ready = rr; rewind = rw;
    push = wv && (m_cnt < D);
    pop  = rr && (m_cnt > 0) && !rw;
    @(posedge clk);
    m_valid = pop;
    if (pop) begin
      m_data = int'(m_mem[m_rp]);
      m_rp = (m_rp + 1) % D;
    end
    if (rw) begin
      m_rp  = 0;
      m_cnt = m_wp + int'(push);
    end else begin
      m_cnt = m_cnt + int'(push) - int'(pop);
    end
    if (push) begin
      m_mem[m_wp] = W'(wd);
      m_wp = (m_wp + 1) % D;
      m_wtot++;
    end
    #(CLK_PERIOD / 4);
    compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_valid = 0; rd_ready = 0; rewind = 0;
    repeat (2) @(posedge clk);
    m_wp = 0; m_rp = 0; m_cnt = 0; m_wtot = 0; m_data = 0; m_valid = 0;
    #(CLK_PERIOD / 4);
    check("R1", "empty in reset", int'(empty), 1);
    check("R1", "full in reset", int'(full), 0);
    check("R1", "half in reset", int'(half_full), 0);
    check("R1", "valid in reset", int'(rd_data_valid), 0);
    check("R1", "data in reset", int'(rd_data), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    do_reset();

    // R4 fill to exactly depth, then R2 extra writes while full
    for (int k = 0; k < D; k++) step("R4", 1, k * 5 + 3, 0, 0);
    check("R4", "full after depth writes", int'(full), 1);
    for (int k = 0; k < 3; k++) step("R2", 1, 500 + k, 0, 0);
    // R6 drain in order, then R3 reads while empty
    for (int k = 0; k < D; k++) step("R6", 0, 0, 1, 0);
    for (int k = 0; k < 3; k++) step("R3", 0, 0, 1, 0);
    // R9 idle cycles hold the data
    for (int k = 0; k < 3; k++) step("R9", 0, 0, 0, 0);

    // R5 half-full boundary in both directions
    do_reset();
    for (int k = 0; k < D / 2 + 1; k++) step("R5", 1, 40 + k, 0, 0);
    check("R5", "half above boundary", int'(half_full), 1);
    step("R5", 0, 0, 1, 0);
    check("R5", "half at boundary", int'(half_full), 0);
    for (int k = 0; k < 4; k++) begin
      step("R5", 1, 90 + k, 0, 0);
      step("R5", 0, 0, 1, 0);
    end

    // R8 simultaneous read and write at several fill levels, then empty
    for (int k = 0; k < 6; k++) step("R8", 1, 120 + k, 1, 0);
    while (m_cnt > 0) step("R8", 0, 0, 1, 0);
    step("R8", 1, 222, 1, 0);
    check("R8", "write only when empty", int'(empty), 0);
    step("R8", 0, 0, 1, 0);

    // R7 rewind after a partial drain
    do_reset();
    for (int k = 0; k < 10; k++) step("R7", 1, 300 + k, 0, 0);
    for (int k = 0; k < 4; k++) step("R7", 0, 0, 1, 0);
    step("R7", 0, 0, 0, 1);
    check("R7", "half after rewind", int'(half_full), 1);
    for (int k = 0; k < 3; k++) step("R7", 0, 0, 1, 0);
    // R10 rewind with a concurrent read and write
    step("R10", 1, 77, 1, 1);
    check("R10", "no read on rewind", int'(rd_data_valid), 0);
    while (m_cnt > 0) step("R10", 0, 0, 1, 0);

    // mixed traffic sweep with periodic reset and rewind
    for (int i = 0; i < 6000; i++) begin
      bit wv, rr, rw;
      int ph;
      if (i % 600 == 0) do_reset();
      ph = (i / 150) % 3;
      wv = ((i * 13) % 7) < (ph == 0 ? 5 : (ph == 1 ? 3 : 4));
      rr = ((i * 11) % 5) < (ph == 0 ? 2 : (ph == 1 ? 4 : 3));
      rw = (i % 97 == 50) && (m_wtot < D - 1);
      step(rw ? "R7" : "R6", wv, (i * 37 + 11) % 512, rr, rw);
    end

    finish_run();
  end
endmodule